// File: doc/BRIEF.md
# Dual-Format Audio Output Queue

This block accepts audio from a processor through a single write port and plays it out at a fixed sample rate on two one-bit outputs, one per channel. The width of each write picks the format. A 16-bit write carries one channel of a stereo sample. The first 16-bit write of a pair is the left channel and the second is the right channel. An 8-bit write carries a mono sample for a small 8-bit DAC-style queue.

The write side and the playback side run on unrelated clocks. The playback clock runs at a fixed multiple of the sample rate: 256 times 44100 Hz by default. Each queue moves its pointers across the clock boundary in Gray code through two-flop synchronizers.

Each queue has its own full flag. The stereo flag is conservative: while it reads low, software may write a whole burst of stereo samples without losing one. Every playback slot takes one sample. A stereo sample takes precedence over a mono one. When both queues are empty, the last value is held. Each channel value drives a first-order sigma-delta modulator.

Top module: `audio_sample_queue`

## Requirements
- R1: After reset, `stereo_full` and `mono_full` are low, both audio outputs are low, and both channel values are zero.
- R2: A playback slot lasts SLOT_CLKS cycles of `play_clk`. The k-th slot boundary is the k·SLOT_CLKS-th rising edge after reset release. Each output is a first-order sigma-delta stream: a 16-bit carry accumulator adds the channel value on every edge and outputs the carry. A channel value of n·256 therefore gives exactly n ones in the SLOT_CLKS edges that follow its boundary.
- R3: 16-bit writes (`wr_word`=1) alternate between left and right, starting with left after reset. The right write commits the pair as one stereo sample. Stereo samples play in write order.
- R4: An 8-bit write (`wr_word`=0) queues `wr_data[7:0]` as a mono sample. When it plays, both channels take the value {byte, 8'h00}.
- R5: At a slot boundary a waiting stereo sample is played before any waiting mono sample.
- R6: `stereo_full` is high exactly when the stereo queue, as seen from the write side, holds more than ST_DEPTH−BURST samples. While it is low, the queue has room for BURST more stereo samples. The defaults are ST_DEPTH=2048 and BURST=1152.
- R7: At a slot boundary where both queues are empty, both channel values keep their previous value.
- R8: A stereo pair committed while the queue holds ST_DEPTH samples is dropped. The stored samples and their order are unaffected.
- R9: `mono_full` is high when the mono queue holds MONO_DEPTH samples. Byte writes made while it is full are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe, one sample word per cycle |
| wr_word | input | 1 | 1 = 16-bit stereo channel write, 0 = 8-bit mono write |
| wr_data | input | 16 | Write data; bits 7:0 only for mono writes |
| stereo_full | output | 1 | Stereo queue lacks room for a full burst |
| mono_full | output | 1 | Mono queue has no free entry |
| play_clk | input | 1 | Playback clock, SLOT_CLKS times the sample rate |
| aud_left | output | 1 | Left-channel one-bit stream |
| aud_right | output | 1 | Right-channel one-bit stream |

## Verification
The assertions assume a clean pairing discipline: the writer never resets mid-pair. They also assume that `wr_en` is only sampled on `wr_clk` and that both clocks keep toggling, so that synchronised pointers settle. The stimulus writes in short bursts shortly after a slot boundary and then waits ten write clocks before sampling the flags. The pointer crossing has therefore settled, and no playback boundary falls inside a burst. All channel values are multiples of 256, so the ones count in each slot identifies the played sample exactly.

// File: rtl/asq_pkg.sv
`timescale 1ns/1ps
package asq_pkg;
    typedef enum logic {PH_LEFT, PH_RIGHT} phase_e;

    typedef struct packed {
        logic [15:0] left;
        logic [15:0] right;
    } stereo_t;
endpackage

// File: rtl/asq_sync2.sv
`timescale 1ns/1ps
module asq_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.s1 = din;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = s_q.s2;
endmodule

// File: rtl/asq_cdc_fifo.sv
`timescale 1ns/1ps
module asq_cdc_fifo #(
    parameter int W  = 32,
    parameter int AW = 11
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    output logic [AW:0]   wr_used,
    input  logic          rd_clk,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          rd_empty
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } ptr_t;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    ptr_t wp_d, wp_q, rp_d, rp_q;
    logic [PW-1:0] rgray_w, wgray_r;
    logic [W-1:0]  mem [DEPTH];
    logic          push_ok, pop_ok;

    // write domain
    assign wr_used = wp_q.bin - to_bin(rgray_w);
    assign push_ok = push && !wr_used[AW];

    always_comb begin
        wp_d = wp_q;
        if (push_ok) begin
            wp_d.bin  = wp_q.bin + 1'b1;
            wp_d.gray = to_gray(wp_d.bin);
        end
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) wp_q <= '0;
        else        wp_q <= wp_d;
    end

    always_ff @(posedge wr_clk) begin
        if (push_ok) mem[wp_q.bin[AW-1:0]] <= wdata;
    end

    asq_sync2 #(.W(PW)) u_r2w (
        .clk  (wr_clk),
        .rst_n(rst_n),
        .din  (rp_q.gray),
        .dout (rgray_w)
    );

    // read domain
    asq_sync2 #(.W(PW)) u_w2r (
        .clk  (rd_clk),
        .rst_n(rst_n),
        .din  (wp_q.gray),
        .dout (wgray_r)
    );

    assign rd_empty = (rp_q.gray == wgray_r);
    assign pop_ok   = pop && !rd_empty;
    assign rdata    = mem[rp_q.bin[AW-1:0]];

    always_comb begin
        rp_d = rp_q;
        if (pop_ok) begin
            rp_d.bin  = rp_q.bin + 1'b1;
            rp_d.gray = to_gray(rp_d.bin);
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) rp_q <= '0;
        else        rp_q <= rp_d;
    end
endmodule

// File: rtl/asq_sdm.sv
`timescale 1ns/1ps
module asq_sdm #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic         bit_out
);
    typedef struct packed {
        logic [W-1:0] acc;
        logic         bit_v;
    } sdm_t;

    sdm_t m_d, m_q;
    logic [W:0] sum;

    always_comb begin
        sum      = {1'b0, m_q.acc} + {1'b0, level};
        m_d.acc  = sum[W-1:0];
        m_d.bit_v = sum[W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign bit_out = m_q.bit_v;
endmodule

// File: rtl/audio_sample_queue.sv
`timescale 1ns/1ps
module audio_sample_queue #(
    parameter int ST_AW     = 11,
    parameter int BURST     = 1152,
    parameter int MONO_AW   = 4,
    parameter int SLOT_CLKS = 256
) (
    input  logic        wr_clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_word,
    input  logic [15:0] wr_data,
    output logic        stereo_full,
    output logic        mono_full,
    input  logic        play_clk,
    output logic        aud_left,
    output logic        aud_right
);
    import asq_pkg::*;

    localparam int ST_DEPTH = 1 << ST_AW;
    localparam int CW       = $clog2(SLOT_CLKS);
    localparam logic [ST_AW:0] ST_LIMIT = (ST_AW + 1)'(ST_DEPTH - BURST);
    localparam logic [CW-1:0]  SLOT_END = CW'(SLOT_CLKS - 1);

    typedef struct packed {
        phase_e      phase;
        logic [15:0] left_hold;
    } wr_state_t;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [15:0]   pcm_l;
        logic [15:0]   pcm_r;
    } play_state_t;

    wr_state_t   w_d, w_q;
    play_state_t p_d, p_q;

    logic          st_push, mono_push, st_pop, mono_pop, tick;
    logic          st_empty, mono_empty;
    stereo_t       st_wdata, st_rd;
    logic [31:0]   st_rdata;
    logic [7:0]    mono_rdata;
    logic [ST_AW:0]   st_used;
    logic [MONO_AW:0] mono_used;

    // write side: width selects format, words pair up left then right
    always_comb begin
        w_d       = w_q;
        st_push   = 1'b0;
        mono_push = 1'b0;
        if (wr_en) begin
            if (wr_word) begin
                if (w_q.phase == PH_LEFT) begin
                    w_d.left_hold = wr_data;
                    w_d.phase     = PH_RIGHT;
                end else begin
                    st_push   = 1'b1;
                    w_d.phase = PH_LEFT;
                end
            end else begin
                mono_push = 1'b1;
            end
        end
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) w_q <= '{phase: PH_LEFT, left_hold: '0};
        else        w_q <= w_d;
    end

    assign st_wdata    = '{left: w_q.left_hold, right: wr_data};
    assign stereo_full = st_used > ST_LIMIT;
    assign mono_full   = mono_used[MONO_AW];

    asq_cdc_fifo #(.W(32), .AW(ST_AW)) u_st_q (
        .wr_clk  (wr_clk),
        .rst_n   (rst_n),
        .push    (st_push),
        .wdata   (st_wdata),
        .wr_used (st_used),
        .rd_clk  (play_clk),
        .pop     (st_pop),
        .rdata   (st_rdata),
        .rd_empty(st_empty)
    );

    asq_cdc_fifo #(.W(8), .AW(MONO_AW)) u_mono_q (
        .wr_clk  (wr_clk),
        .rst_n   (rst_n),
        .push    (mono_push),
        .wdata   (wr_data[7:0]),
        .wr_used (mono_used),
        .rd_clk  (play_clk),
        .pop     (mono_pop),
        .rdata   (mono_rdata),
        .rd_empty(mono_empty)
    );

    // playback side: one slot per SLOT_CLKS, stereo before mono, hold on empty
    assign st_rd    = stereo_t'(st_rdata);
    assign tick     = (p_q.cnt == SLOT_END);
    assign st_pop   = tick && !st_empty;
    assign mono_pop = tick && st_empty && !mono_empty;

    always_comb begin
        p_d     = p_q;
        p_d.cnt = tick ? '0 : p_q.cnt + 1'b1;
        if (st_pop) begin
            p_d.pcm_l = st_rd.left;
            p_d.pcm_r = st_rd.right;
        end else if (mono_pop) begin
            p_d.pcm_l = {mono_rdata, 8'h00};
            p_d.pcm_r = {mono_rdata, 8'h00};
        end
    end

    always_ff @(posedge play_clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    logic [15:0] chan_lvl [2];
    logic [1:0]  chan_bit;

    assign chan_lvl[0] = p_q.pcm_l;
    assign chan_lvl[1] = p_q.pcm_r;

    for (genvar c = 0; c < 2; c++) begin : g_chan
        asq_sdm #(.W(16)) u_sdm (
            .clk    (play_clk),
            .rst_n  (rst_n),
            .level  (chan_lvl[c]),
            .bit_out(chan_bit[c])
        );
    end

    assign aud_left  = chan_bit[0];
    assign aud_right = chan_bit[1];
endmodule

// File: rtl/asq_chk.sv
`timescale 1ns/1ps
module asq_chk #(
    parameter int ST_AW   = 11,
    parameter int MONO_AW = 4
) (
    input logic              wr_clk,
    input logic              play_clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_word,
    input logic              phase_right,
    input logic [ST_AW:0]    st_used,
    input logic [MONO_AW:0]  mono_used,
    input logic              tick,
    input logic              st_empty,
    input logic              mono_empty,
    input logic [15:0]       pcm_l,
    input logic [15:0]       pcm_r
);
    localparam logic [ST_AW:0] ST_CAP = (ST_AW + 1)'(1 << ST_AW);

    AST_PAIR_TOGGLE: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_en && wr_word |=> phase_right != $past(phase_right)); // R3

    AST_USED_BOUND: assert property (@(posedge wr_clk) disable iff (!rst_n)
        st_used <= ST_CAP); // R8

    AST_USED_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
        st_used > $past(st_used) |-> st_used == $past(st_used) + 1'b1); // R8

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_en && wr_word && phase_right && st_used[ST_AW] |=> st_used <= $past(st_used)); // R8

    AST_MONO_DROP: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_en && !wr_word && mono_used[MONO_AW] |=> mono_used <= $past(mono_used)); // R9

    AST_HOLD_EMPTY: assert property (@(posedge play_clk) disable iff (!rst_n)
        tick && st_empty && mono_empty |=> $stable(pcm_l) && $stable(pcm_r)); // R7

    AST_MONO_BOTH: assert property (@(posedge play_clk) disable iff (!rst_n)
        tick && st_empty && !mono_empty |=> pcm_l == pcm_r && pcm_l[7:0] == 8'h00); // R4
endmodule

bind audio_sample_queue asq_chk #(.ST_AW(ST_AW), .MONO_AW(MONO_AW)) u_chk (
    .wr_clk     (wr_clk),
    .play_clk   (play_clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_word    (wr_word),
    .phase_right(w_q.phase == asq_pkg::PH_RIGHT),
    .st_used    (st_used),
    .mono_used  (mono_used),
    .tick       (tick),
    .st_empty   (st_empty),
    .mono_empty (mono_empty),
    .pcm_l      (p_q.pcm_l),
    .pcm_r      (p_q.pcm_r)
);

// File: tb/audio_sample_queue_test.sv
`timescale 1ns/1ps
module audio_sample_queue_test;
    localparam int ST_AW      = 5;
    localparam int BURST      = 12;
    localparam int MONO_AW    = 3;
    localparam int SLOT       = 256;
    localparam int ST_DEPTH   = 1 << ST_AW;
    localparam int MONO_DEPTH = 1 << MONO_AW;

    logic        wr_clk = 1'b0, play_clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_word = 1'b0;
    logic [15:0] wr_data = '0;
    logic        stereo_full, mono_full, aud_left, aud_right;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [15:0] exp_l[$], exp_r[$];
    logic [7:0]  exp_m[$];
    logic [15:0] cur_l = '0, cur_r = '0;
    string       cur_tag = "R1";
    event        tick_ev;

    always #5 wr_clk   = ~wr_clk;
    always #7 play_clk = ~play_clk;

    audio_sample_queue #(.ST_AW(ST_AW), .BURST(BURST), .MONO_AW(MONO_AW), .SLOT_CLKS(SLOT)) uut (
        .wr_clk     (wr_clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_word    (wr_word),
        .wr_data    (wr_data),
        .stereo_full(stereo_full),
        .mono_full  (mono_full),
        .play_clk   (play_clk),
        .aud_left   (aud_left),
        .aud_right  (aud_right)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic put(input logic word, input logic [15:0] d);
        @(negedge wr_clk);
        wr_en = 1'b1; wr_word = word; wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    // driver: writes a stereo pair and records it if the queue has room (R3, R8)
    task automatic push_pair(input int kl, input int kr);
        if (exp_l.size() < ST_DEPTH) begin
            exp_l.push_back(16'(kl << 8));
            exp_r.push_back(16'(kr << 8));
        end
        put(1'b1, 16'(kl << 8));
        put(1'b1, 16'(kr << 8));
    endtask

    task automatic push_mono(input int b);
        if (exp_m.size() < MONO_DEPTH) exp_m.push_back(8'(b));
        put(1'b0, {8'hA5, 8'(b)});
    endtask

    task automatic flags(input string tag);
        repeat (10) @(negedge wr_clk);
        check(stereo_full == (exp_l.size() > ST_DEPTH - BURST), {tag, " stereo_full"},
              int'(stereo_full), int'(exp_l.size() > ST_DEPTH - BURST));
        check(mono_full == (exp_m.size() == MONO_DEPTH), {tag, " mono_full"},
              int'(mono_full), int'(exp_m.size() == MONO_DEPTH));
    endtask

    task automatic after_tick();
        @(tick_ev);
        repeat (10) @(negedge wr_clk);
    endtask

    // monitor: counts ones per slot (R2) and pops the scoreboard at each boundary
    initial begin
        int n = 0, cl = 0, cr = 0;
        @(posedge rst_n);
        forever begin
            @(posedge play_clk);
            #1;
            n++;
            cl += int'(aud_left);
            cr += int'(aud_right);
            if (n % SLOT == 0) begin
                check(cl == int'(cur_l >> 8), {cur_tag, " R2 left"}, cl, int'(cur_l >> 8));
                check(cr == int'(cur_r >> 8), {cur_tag, " R2 right"}, cr, int'(cur_r >> 8));
                cl = 0; cr = 0;
                if (exp_l.size() > 0) begin
                    cur_l = exp_l.pop_front(); cur_r = exp_r.pop_front(); cur_tag = "R3/R8";
                end else if (exp_m.size() > 0) begin
                    cur_l = {exp_m.pop_front(), 8'h00}; cur_r = cur_l; cur_tag = "R4/R5";
                end else begin
                    cur_tag = "R7";
                end
                -> tick_ev;
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #102 rst_n = 1'b1;
        repeat (3) @(negedge wr_clk);
        check(stereo_full == 1'b0, "R1 stereo_full", int'(stereo_full), 0);
        check(mono_full == 1'b0, "R1 mono_full", int'(mono_full), 0);
        check(aud_left == 1'b0 && aud_right == 1'b0, "R1 outputs", int'({aud_left, aud_right}), 0);

        after_tick();
        for (int i = 0; i < 3; i++) push_pair(10 + i, 40 + 3 * i);
        push_mono(77);
        push_mono(5);
        flags("R6 R9 small");

        repeat (8) @(tick_ev);

        after_tick();
        for (int i = 0; i < ST_DEPTH - BURST; i++) push_pair(i + 1, 200 - i);
        flags("R6 at limit");
        push_pair(99, 98);
        flags("R6 over limit");

        after_tick();
        for (int i = 0; i < 14; i++) push_pair(120 + i, 60 + i);
        flags("R8 overflow");
        for (int i = 0; i < MONO_DEPTH + 2; i++) push_mono(30 + i);
        flags("R9 mono full");

        repeat (ST_DEPTH + MONO_DEPTH + 4) @(tick_ev);
        flags("R6 drained");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule